// File: doc/BRIEF.md
# Periodic Stepwise Drive-Strength Trim Controller

This block keeps a binary-weighted output driver strength code near its optimum while supply voltage and temperature drift. A free-running cycle counter fires an evaluation once every `PERIOD` clock cycles. At each evaluation the controller samples an external comparator and moves the code by no more than one least-significant step. A "too weak" result raises the code and a "too strong" result lowers it. A match holds the code, and so does the invalid case where both flags are set.

The comparator, the sense resistor and the driver itself are outside the block. Only the comparator's two flags come in, and only the code and an evaluation strobe go out. Calibration never stops, so the code keeps tracking drift for as long as the clock runs. The code leaves reset at mid-scale. At either end of the range it saturates rather than wrapping.

Top module: `drive_trim_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the code becomes mid-scale (2^(CODE_W-1); 4 when CODE_W=3) and `eval_o` becomes 0.
- R2: `eval_o` is high for exactly one cycle out of every `PERIOD`. The first pulse follows the `PERIOD`-th rising edge after reset is released.
- R3: At an evaluation where `weak_i`=1 and `strong_i`=0, the code rises by one. Larger codes mean stronger drive.
- R4: At an evaluation where `strong_i`=1 and `weak_i`=0, the code falls by one.
- R5: At an evaluation where both comparator flags are 0 (matched), the code is unchanged.
- R6: At an evaluation where both comparator flags are 1 (invalid), the code is unchanged.
- R7: A rise request at the all-ones code leaves the code at all-ones.
- R8: A fall request at the all-zeros code leaves the code at all-zeros.
- R9: Between evaluations the code holds, whatever the comparator inputs do.
- R10: From one cycle to the next, the code never moves by more than one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strong_i | input | 1 | Comparator flag: driver stronger than the target |
| weak_i | input | 1 | Comparator flag: driver weaker than the target |
| code_o | output | CODE_W | Drive strength code (binary weighted) |
| eval_o | output | 1 | One-cycle strobe marking the cycle in which an evaluation result appears |

## Verification
The comparator flags are sampled at the rising edge on which the period counter completes. The new code and the `eval_o` strobe both become visible right after that same edge, one register stage from the sampled inputs. The bench drives the flags at falling edges and advances its own arithmetic model at each rising edge. It compares the code and strobe at the following falling edge, so every result is checked in the cycle it is due. It counts edges from the release of reset, so it knows which edges are evaluations.

// File: rtl/drvcal_pkg.sv
package drvcal_pkg;

    // Decision taken at an evaluation edge
    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adj_e;

    // Comparator sample
    typedef struct packed {
        logic too_strong;
        logic too_weak;
    } cmp_s;

    // Map comparator flags to an adjustment direction
    function automatic adj_e decide(input cmp_s c);
        adj_e r;
        unique case ({c.too_strong, c.too_weak})
            2'b01:   r = ADJ_UP;
            2'b10:   r = ADJ_DOWN;
            default: r = ADJ_HOLD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/drvcal_timer.sv
module drvcal_timer #(
    parameter int PERIOD = 256
) (
    input  logic clk,
    input  logic rst,
    output logic fire_o
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    initial begin
        if (PERIOD < 2) $error("PERIOD must be at least 2");
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fire_o = (cnt_q == LAST);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R2
    fire_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> (cnt_q == '0));

endmodule

// File: rtl/drvcal_decide.sv
module drvcal_decide
    import drvcal_pkg::*;
(
    input  logic strong_i,
    input  logic weak_i,
    output adj_e adj_o
);
    cmp_s cmp;

    always_comb begin
        cmp.too_strong = strong_i;
        cmp.too_weak   = weak_i;
        adj_o          = decide(cmp);
    end

endmodule

// File: rtl/drvcal_stepper.sv
module drvcal_stepper
    import drvcal_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  adj_e              adj_i,
    output logic [CODE_W-1:0] code_o,
    output logic              eval_o
);
    localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] TOP  = '1;
    localparam logic [CODE_W-1:0] ZERO = '0;

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_d;
    logic              eval_q;

    always_comb begin
        code_d = code_q;
        unique case (adj_i)
            ADJ_UP:   if (code_q != TOP)  code_d = code_q + 1'b1;
            ADJ_DOWN: if (code_q != ZERO) code_d = code_q - 1'b1;
            default:  code_d = code_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= MID;
            eval_q <= 1'b0;
        end else begin
            eval_q <= fire_i;
            if (fire_i) code_q <= code_d;
        end
    end

    assign code_o = code_q;
    assign eval_o = eval_q;

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(fire_i) |-> $stable(code_q));

    // R10
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        (code_q == $past(code_q)) || (code_q == $past(code_q) + 1'b1) ||
        ($past(code_q) == code_q + 1'b1));

    // R7
    no_top_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(code_q) == TOP) |-> (code_q != ZERO));

    // R8
    no_bottom_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(code_q) == ZERO) |-> (code_q != TOP));

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        eval_q |=> !eval_q);

endmodule

// File: rtl/drive_trim_ctrl.sv
module drive_trim_ctrl
    import drvcal_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int PERIOD = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strong_i,
    input  logic              weak_i,
    output logic [CODE_W-1:0] code_o,
    output logic              eval_o
);
    logic fire;
    adj_e adj_req;
    adj_e adj_gated;

    drvcal_timer #(.PERIOD(PERIOD)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .fire_o (fire)
    );

    drvcal_decide u_decide (
        .strong_i (strong_i),
        .weak_i   (weak_i),
        .adj_o    (adj_req)
    );

    assign adj_gated = fire ? adj_req : ADJ_HOLD;

    drvcal_stepper #(.CODE_W(CODE_W)) u_step (
        .clk    (clk),
        .rst    (rst),
        .fire_i (fire),
        .adj_i  (adj_gated),
        .code_o (code_o),
        .eval_o (eval_o)
    );

    // R5
    match_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !strong_i && !weak_i) |=> $stable(code_o));

    // R6
    invalid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && strong_i && weak_i) |=> $stable(code_o));

endmodule

// File: tb/sim_drive_trim_ctrl.sv
module sim_drive_trim_ctrl;
    localparam int W = 3;
    localparam int P = 5;
    localparam int MAXC = (1 << W) - 1;
    localparam int MIDC = 1 << (W - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s_in = 1'b0;
    logic w_in = 1'b0;
    logic [W-1:0] code;
    logic eval;

    int checks = 0;
    int fails = 0;
    int edges = 0;
    int exp_code = MIDC;
    int prev_code = MIDC;
    bit exp_eval = 1'b0;
    string ctag = "R9";
    bit finished = 1'b0;

    always #5 clk = ~clk;

    drive_trim_ctrl #(.CODE_W(W), .PERIOD(P)) u0 (
        .clk(clk), .rst(rst), .strong_i(s_in), .weak_i(w_in),
        .code_o(code), .eval_o(eval)
    );

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Drive flags at a falling edge, model the rising edge, check at the next falling edge
    task automatic cyc(bit s, bit w);
        s_in = s;
        w_in = w;
        @(posedge clk);
        edges++;
        if (edges == P) begin
            edges = 0;
            exp_eval = 1'b1;
            if (s && w) ctag = "R6";
            else if (w && exp_code == MAXC) ctag = "R7";
            else if (s && exp_code == 0) ctag = "R8";
            else if (w) ctag = "R3";
            else if (s) ctag = "R4";
            else ctag = "R5";
            if (w && !s && exp_code < MAXC) exp_code++;
            if (s && !w && exp_code > 0) exp_code--;
        end else begin
            exp_eval = 1'b0;
            ctag = "R9";
        end
        @(negedge clk);
        check("R2", int'(eval), int'(exp_eval));
        check(ctag, int'(code), exp_code);
        check("R10", ((int'(code) - prev_code) <= 1 && (prev_code - int'(code)) <= 1) ? 1 : 0, 1);
        prev_code = int'(code);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", int'(code), MIDC);
        check("R1", int'(eval), 0);
        rst = 1'b0;
        edges = 0;
        exp_code = MIDC;
        prev_code = MIDC;
    endtask

    initial begin
        logic [7:0] lfsr;
        do_reset();
        // R3 then R7: climb to the top and stay there
        repeat (12 * P) cyc(1'b0, 1'b1);
        // R4 then R8: descend to zero and stay there
        repeat (12 * P) cyc(1'b1, 1'b0);
        // R3 sweep up through every code again
        repeat (9 * P) cyc(1'b0, 1'b1);
        // R5 matched, R6 invalid
        repeat (3 * P) cyc(1'b0, 1'b0);
        repeat (3 * P) cyc(1'b1, 1'b1);
        // R9: flags change every cycle, pseudo-random
        lfsr = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[0], lfsr[3]);
        end
        // R1 mid-period reset, then R2 timing restarts
        repeat (2) cyc(1'b0, 1'b1);
        do_reset();
        repeat (3 * P) cyc(1'b1, 1'b0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule